// File: doc/BRIEF.md
# Scaling Residue-to-Binary Converter

This block takes a number held as four residues and returns a scaled binary approximation of it. The four channels use the moduli 221, 229, 233 and 241, whose product M = 2,841,847,177 spans just over 31 bits. The result is X·2^n/M for an n-bit output, so the binary word is the value's fraction of the full dynamic range. It does not rebuild the full 32-bit integer. Each residue addresses its own read-only table, and the four table words are summed with ordinary binary adders, whose carry out of the top bit is simply dropped.

Each table entry is the channel's fractional reconstruction term, ((x·w_i mod m_i)/m_i)·2^n, rounded to n bits. Here w_i is the inverse of M/m_i modulo m_i. The tables are computed while the design is elaborated. No values are loaded at run time. The pipeline never stalls. A valid flag travels alongside the data and marks the cycles whose output is meaningful.

Top module: `rns_scale_conv`

## Requirements
- R1: Channel 0 carries the residue modulo 221, channel 1 modulo 229, channel 2 modulo 233 and channel 3 modulo 241. Whenever in_valid is high, each residue is below its modulus; the largest legal residues (m_i − 1) are accepted.
- R2: For any X in [0, M), when the residues are X mod m_i, the result out_scaled lies within 4 LSB of floor(X·2^n/M), with the distance measured modulo 2^n.
- R3: out_valid rises exactly LAT = 1 + S cycles after in_valid is sampled high. S is the number of adder stages: 3 for n = 24, 2 for n = 16 and 1 for n = 8, so the default gives LAT = 4.
- R4: All-zero residues give an out_scaled of exactly 0.
- R5: The table sum is taken modulo 2^n. For X near M, a result just above 2^n − 1 wraps to a small value and still meets R2.
- R6: While rst_n is low, out_valid and out_scaled are 0.
- R7: Inputs that are valid on consecutive cycles produce one result per cycle, in input order.
- R8: A cycle with in_valid low produces a cycle with out_valid low, LAT cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The residues on this cycle are to be converted |
| res_ch0 | input | 8 | Residue modulo 221 |
| res_ch1 | input | 8 | Residue modulo 229 |
| res_ch2 | input | 8 | Residue modulo 233 |
| res_ch3 | input | 8 | Residue modulo 241 |
| out_valid | output | 1 | out_scaled holds a result |
| out_scaled | output | OUT_W | Scaled result, X·2^n/M rounded, modulo 2^n |

## Verification
The assertions take for granted that every residue presented with in_valid high is below its channel's modulus. Table rows beyond a modulus hold arithmetically meaningless values, and the range checks catch any such input. The stimulus builds each input from an integer X drawn below M and reduces it by each modulus, so the residues are always legal and always consistent with one another. It also drives X = M − 1, which puts every channel at its maximum legal residue. During invalid cycles the residue lines carry legal but unrelated values.

// File: rtl/rns_conv_pkg.sv
package rns_conv_pkg;

    localparam int NUM_CH = 4;
    localparam int RES_W  = 8;

    // channel order is fixed: each table depends on its own modulus
    function automatic longint unsigned mod_of(input int ch);
        case (ch)
            0:       return 64'd221;
            1:       return 64'd229;
            2:       return 64'd233;
            default: return 64'd241;
        endcase
    endfunction

    function automatic longint unsigned dyn_range();
        longint unsigned p;
        p = 64'd1;
        for (int c = 0; c < NUM_CH; c++) begin
            p = p * mod_of(c);
        end
        return p;
    endfunction

    // multiplicative inverse of (M / m_ch) modulo m_ch, found by search
    function automatic longint unsigned crt_inv(input int ch);
        longint unsigned m;
        longint unsigned r;
        longint unsigned found;
        m     = mod_of(ch);
        r     = (dyn_range() / m) % m;
        found = 64'd0;
        for (int j = 1; j < 256; j++) begin
            if (found == 64'd0 && longint'(j) < m && ((r * longint'(j)) % m) == 64'd1) begin
                found = longint'(j);
            end
        end
        return found;
    endfunction

    // adder pipeline depth chosen by output width
    function automatic int stages_for(input int w);
        if (w > 16) return 3;
        if (w > 8)  return 2;
        return 1;
    endfunction

endpackage

// File: rtl/rns_lut_chan.sv
module rns_lut_chan
    import rns_conv_pkg::*;
#(
    parameter int CH    = 0,
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] addr,
    output logic [OUT_W-1:0] term
);

    localparam int DEPTH = 2 ** RES_W;
    localparam longint unsigned MOD_V = mod_of(CH);

    function automatic logic [DEPTH*OUT_W-1:0] build_rom();
        logic [DEPTH*OUT_W-1:0] rom;
        longint unsigned inv;
        longint unsigned t;
        longint unsigned v;
        rom = '0;
        inv = crt_inv(CH);
        for (int x = 0; x < DEPTH; x++) begin
            t = (longint'(x) * inv) % MOD_V;
            v = ((t << OUT_W) + (MOD_V / 2)) / MOD_V;
            rom[x*OUT_W +: OUT_W] = OUT_W'(v);
        end
        return rom;
    endfunction

    localparam logic [DEPTH*OUT_W-1:0] ROM = build_rom();

    typedef struct packed {
        logic [OUT_W-1:0] term;
    } lut_st_t;

    lut_st_t lut_d, lut_q;

    always_comb begin
        lut_d      = lut_q;
        lut_d.term = ROM[int'(addr)*OUT_W +: OUT_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lut_q <= '0;
        end else begin
            lut_q <= lut_d;
        end
    end

    assign term = lut_q.term;

    // R4
    zero_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr) == '0 |-> term == '0);

endmodule

// File: rtl/rns_sum_tree.sv
module rns_sum_tree
    import rns_conv_pkg::*;
#(
    parameter int OUT_W  = 24,
    parameter int STAGES = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CH-1:0][OUT_W-1:0]  terms,
    output logic [OUT_W-1:0]              sum
);

    localparam int LO_W = OUT_W / 2;
    localparam int HI_W = OUT_W - LO_W;

    if (STAGES == 1) begin : g_one
        typedef struct packed {
            logic [OUT_W-1:0] s;
        } tr1_t;
        tr1_t tr_d, tr_q;

        always_comb begin
            tr_d   = tr_q;
            tr_d.s = terms[0] + terms[1] + terms[2] + terms[3];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) tr_q <= '0;
            else        tr_q <= tr_d;
        end

        assign sum = tr_q.s;
    end else if (STAGES == 2) begin : g_two
        typedef struct packed {
            logic [OUT_W-1:0] p0;
            logic [OUT_W-1:0] p1;
            logic [OUT_W-1:0] s;
        } tr2_t;
        tr2_t tr_d, tr_q;

        always_comb begin
            tr_d    = tr_q;
            tr_d.p0 = terms[0] + terms[1];
            tr_d.p1 = terms[2] + terms[3];
            tr_d.s  = tr_q.p0 + tr_q.p1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) tr_q <= '0;
            else        tr_q <= tr_d;
        end

        assign sum = tr_q.s;
    end else begin : g_three
        typedef struct packed {
            logic [OUT_W-1:0] p0;
            logic [OUT_W-1:0] p1;
            logic [LO_W-1:0]  lo;
            logic             cy;
            logic [HI_W-1:0]  h0;
            logic [HI_W-1:0]  h1;
            logic [OUT_W-1:0] s;
        } tr3_t;
        tr3_t tr_d, tr_q;

        always_comb begin
            tr_d    = tr_q;
            // stage 1: pairwise sums
            tr_d.p0 = terms[0] + terms[1];
            tr_d.p1 = terms[2] + terms[3];
            // stage 2: lower half with carry, upper halves carried along
            {tr_d.cy, tr_d.lo} = {1'b0, tr_q.p0[LO_W-1:0]} + {1'b0, tr_q.p1[LO_W-1:0]};
            tr_d.h0 = tr_q.p0[OUT_W-1:LO_W];
            tr_d.h1 = tr_q.p1[OUT_W-1:LO_W];
            // stage 3: upper half, top carry dropped
            tr_d.s  = {tr_q.h0 + tr_q.h1 + HI_W'(tr_q.cy), tr_q.lo};
        end

        always_ff @(posedge clk) begin
            if (!rst_n) tr_q <= '0;
            else        tr_q <= tr_d;
        end

        assign sum = tr_q.s;
    end

    // cycles since reset, used to keep the look-back inside that window
    logic [2:0]       warm_q;
    logic [OUT_W-1:0] total_now;

    assign total_now = terms[0] + terms[1] + terms[2] + terms[3];

    always_ff @(posedge clk) begin
        if (!rst_n)                   warm_q <= '0;
        else if (warm_q < 3'(STAGES)) warm_q <= warm_q + 3'd1;
    end

    // R5
    wrap_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q == 3'(STAGES) |-> sum == $past(total_now, STAGES));

endmodule

// File: rtl/rns_scale_conv.sv
module rns_scale_conv
    import rns_conv_pkg::*;
#(
    parameter int OUT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       res_ch0,
    input  logic [7:0]       res_ch1,
    input  logic [7:0]       res_ch2,
    input  logic [7:0]       res_ch3,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_scaled
);

    localparam int ADD_STG = stages_for(OUT_W);
    localparam int LAT     = 1 + ADD_STG;

    logic [NUM_CH-1:0][RES_W-1:0] res_arr;
    logic [NUM_CH-1:0][OUT_W-1:0] terms;

    assign res_arr[0] = res_ch0;
    assign res_arr[1] = res_ch1;
    assign res_arr[2] = res_ch2;
    assign res_arr[3] = res_ch3;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        localparam logic [RES_W-1:0] MOD_V = RES_W'(mod_of(ch));

        rns_lut_chan #(
            .CH    (ch),
            .OUT_W (OUT_W)
        ) u_lut (
            .clk   (clk),
            .rst_n (rst_n),
            .addr  (res_arr[ch]),
            .term  (terms[ch])
        );

        // R1
        res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> res_arr[ch] < MOD_V);
    end

    rns_sum_tree #(
        .OUT_W  (OUT_W),
        .STAGES (ADD_STG)
    ) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .terms (terms),
        .sum   (out_scaled)
    );

    typedef struct packed {
        logic [LAT-1:0] vld;
    } vp_st_t;

    vp_st_t vp_d, vp_q;

    always_comb begin
        vp_d     = vp_q;
        vp_d.vld = {vp_q.vld[LAT-2:0], in_valid};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vp_q <= '0;
        else        vp_q <= vp_d;
    end

    assign out_valid = vp_q.vld[LAT-1];

    logic [2:0] warm_q;
    logic       zero_in;

    assign zero_in = in_valid && (res_arr == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)                warm_q <= '0;
        else if (warm_q < 3'(LAT)) warm_q <= warm_q + 3'd1;
    end

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q == 3'(LAT) |-> out_valid == $past(in_valid, LAT));

    // R4
    zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 3'(LAT) && $past(zero_in, LAT)) |-> out_scaled == '0);

    // R6
    reset_quiet_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> !out_valid);

endmodule

// File: tb/rns_scale_conv_tb_top.sv
module rns_scale_conv_tb_top;

    localparam int N   = 24;
    localparam int LAT = 4;
    localparam longint unsigned M    = 64'd221 * 64'd229 * 64'd233 * 64'd241;
    localparam longint unsigned MASK = (64'd1 << N) - 64'd1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   res_ch0 = '0, res_ch1 = '0, res_ch2 = '0, res_ch3 = '0;
    logic         out_valid;
    logic [N-1:0] out_scaled;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    bit              hv   [LAT];
    longint unsigned hx   [LAT];
    int              htag [LAT];

    always #10 clk = ~clk;

    rns_scale_conv #(.OUT_W(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .res_ch0    (res_ch0),
        .res_ch1    (res_ch1),
        .res_ch2    (res_ch2),
        .res_ch3    (res_ch3),
        .out_valid  (out_valid),
        .out_scaled (out_scaled)
    );

    function automatic longint unsigned expect_of(input longint unsigned x);
        return (x << N) / M;
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            4:       return "R4";
            5:       return "R1 R5";
            7:       return "R7";
            default: return "R2";
        endcase
    endfunction

    // check the slot due now, shift history, then drive the next input
    task automatic step(input bit v, input longint unsigned x, input int tag);
        longint unsigned e;
        longint unsigned got;
        longint unsigned d;
        n_chk++;
        if (out_valid !== hv[LAT-1]) begin
            n_fail++;
            $display("FAIL %s out_valid=%0b expected=%0b",
                     hv[LAT-1] ? "R3" : "R8", out_valid, hv[LAT-1]);
        end
        if (hv[LAT-1]) begin
            n_chk++;
            e   = expect_of(hx[LAT-1]);
            got = longint'(out_scaled);
            d   = (got - e) & MASK;
            if (htag[LAT-1] == 4) begin
                if (got != 64'd0) begin
                    n_fail++;
                    $display("FAIL R4 out_scaled=%0d expected=0", got);
                end
            end else if (!(d <= 64'd4 || d >= (MASK - 64'd3))) begin
                n_fail++;
                $display("FAIL %s X=%0d out_scaled=%0d expected=%0d (+-4)",
                         tag_name(htag[LAT-1]), hx[LAT-1], got, e);
            end
        end
        for (int i = LAT-1; i > 0; i--) begin
            hv[i]   = hv[i-1];
            hx[i]   = hx[i-1];
            htag[i] = htag[i-1];
        end
        hv[0]   = v;
        hx[0]   = x;
        htag[0] = tag;
        in_valid = v;
        res_ch0  = 8'(x % 64'd221);
        res_ch1  = 8'(x % 64'd229);
        res_ch2  = 8'(x % 64'd233);
        res_ch3  = 8'(x % 64'd241);
        @(negedge clk);
    endtask

    function automatic longint unsigned rand_x();
        return {32'($urandom), 32'($urandom)} % M;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < LAT; i++) begin
            hv[i] = 1'b0; hx[i] = 0; htag[i] = 2;
        end
        repeat (5) @(negedge clk);
        // R6: quiet outputs under reset
        n_chk++;
        if (out_valid !== 1'b0 || out_scaled !== '0) begin
            n_fail++;
            $display("FAIL R6 out_valid=%0b out_scaled=%0d expected=0/0", out_valid, out_scaled);
        end
        rst_n = 1'b1;
        // directed corners
        step(1'b1, 64'd0, 4);
        step(1'b1, 64'd1, 2);
        step(1'b1, M - 64'd1, 5);
        step(1'b0, 64'd7, 2);
        step(1'b1, M / 2, 2);
        step(1'b1, M - 64'd2, 5);
        step(1'b0, 64'd0, 2);
        step(1'b1, 64'd0, 4);
        // R7: unbroken burst
        for (int i = 0; i < 40; i++) begin
            step(1'b1, rand_x(), 7);
        end
        // R2 / R8: random values with bubbles
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, rand_x(), 2);
        end
        for (int i = 0; i < LAT + 2; i++) begin
            step(1'b0, 64'd0, 2);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog expired, results still pending expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule